// File: doc/BRIEF.md
# Peak-Sensing Conversion Sequencer

This block runs the control side of one peak-sensing measurement. While idle, it waits for a rising edge on the gate input. It then lets the external peak-hold stage track the input until the analog comparator reports that the first peak has been reached. From that point the held level is frozen. After a programmable settling time the block issues a one-cycle start strobe to the ADC and waits for the ADC's done handshake. It captures the 12-bit result, then discharges the hold capacitor for a programmable number of cycles before it returns to idle.

The busy flag is high in every phase except idle, and gate edges are locked out for that whole time. Two situations abort the cycle and lead straight to the discharge phase without a result. One is a gate that closes before any peak is seen. The other is an ADC that does not answer within the digitise timeout, which defaults to 240 cycles: about 6 µs at a 40 MHz clock. The analog front end and the converter are outside the block.

Top module: `peak_conv_seq`

## Requirements
- R1: After reset, `busy_o`, `hold_o`, `discharge_o`, `adc_start_o` and `valid_o` are all low.
- R2: In idle, a rising edge of `gate_i` (high now, low in the previous cycle) raises `busy_o` one cycle later, and `hold_o` stays low while the block waits for the peak.
- R3: `peak_i` high while the block waits for the peak raises `hold_o` on the next cycle. `hold_o` then stays high until the discharge phase. `hold_o` and `discharge_o` are never high together.
- R4: After `hold_o` rises, the block waits exactly SETTLE_CYC cycles (default 16) with `adc_start_o` low. It then drives `adc_start_o` high for exactly one cycle.
- R5: `adc_done_i` high while the block waits for the ADC latches `adc_data_i` into `data_o` and produces a one-cycle `valid_o` pulse in the first discharge cycle.
- R6: `discharge_o` stays high for exactly CLEAR_CYC cycles (default 8). The block is then idle with `busy_o` low.
- R7: If `gate_i` falls before `peak_i` is seen, the block enters the discharge phase and produces no `valid_o` pulse.
- R8: Gate edges while `busy_o` is high are ignored, and so is a gate that is still high when the block returns to idle. Only a fresh rising edge starts a new cycle.
- R9: If `adc_done_i` does not arrive within CONV_TIMEOUT cycles (default 240) after the start strobe, the block enters the discharge phase and produces no `valid_o` pulse.
- R10: `busy_o` is high whenever `hold_o`, `discharge_o` or `adc_start_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_i | input | 1 | Acquisition gate |
| peak_i | input | 1 | Peak-reached flag from the analog comparator |
| adc_done_i | input | 1 | ADC conversion finished |
| adc_data_i | input | 12 | ADC conversion result |
| adc_start_o | output | 1 | One-cycle ADC start strobe |
| hold_o | output | 1 | Freeze the peak-hold stage |
| discharge_o | output | 1 | Discharge the hold capacitor |
| busy_o | output | 1 | Sequencer not idle |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | 12 | Captured conversion result |

## Verification
The hardest case to reach is the digitise timeout. It needs an ADC model that takes the start strobe but never answers, and it needs the bench to count the exact number of cycles between the strobe and the discharge. The bench's ADC model can be switched off for one pass to do this. Gate lockout is tested in two ways. A gate pulse is injected during settling. A separate pass keeps the gate high through a whole cycle and then checks that no second acquisition begins.

// File: rtl/pkseq_pkg.sv
package pkseq_pkg;
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_ACQ    = 3'd1,
      PH_SETTLE = 3'd2,
      PH_START  = 3'd3,
      PH_CONV   = 3'd4,
      PH_CLEAR  = 3'd5
   } phase_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/pkseq_timer.sv
module pkseq_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (restart)   cnt_q <= '0;
      else if (!expired)  cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == limit - 1'b1);
endmodule

// File: rtl/pkseq_fsm.sv
module pkseq_fsm
   import pkseq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   gate_i,
   input  logic   peak_i,
   input  logic   adc_done_i,
   input  logic   tmr_exp,
   output phase_t phase_q,
   output logic   phase_chg
);
   phase_t phase_d;
   logic   gate_q;
   logic   gate_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         gate_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         gate_q  <= gate_i;
      end
   end

   assign gate_rise = gate_i & ~gate_q;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:   if (gate_rise) phase_d = PH_ACQ;
         PH_ACQ: begin
            if (peak_i)       phase_d = PH_SETTLE;
            else if (!gate_i) phase_d = PH_CLEAR;
         end
         PH_SETTLE: if (tmr_exp) phase_d = PH_START;
         PH_START:  phase_d = PH_CONV;
         PH_CONV:   if (adc_done_i || tmr_exp) phase_d = PH_CLEAR;
         PH_CLEAR:  if (tmr_exp) phase_d = PH_IDLE;
         default:   phase_d = PH_IDLE;
      endcase
   end

   assign phase_chg = (phase_d != phase_q);
endmodule

// File: rtl/pkseq_capture.sv
module pkseq_capture #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [DATA_W-1:0] din,
   output logic              valid,
   output logic [DATA_W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else begin
         valid <= take;
         if (take) dout <= din;
      end
   end
endmodule

// File: rtl/peak_conv_seq.sv
module peak_conv_seq
   import pkseq_pkg::*;
#(
   parameter int DATA_W       = 12,
   parameter int SETTLE_CYC   = 16,
   parameter int CLEAR_CYC    = 8,
   parameter int CONV_TIMEOUT = 240
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate_i,
   input  logic              peak_i,
   input  logic              adc_done_i,
   input  logic [DATA_W-1:0] adc_data_i,
   output logic              adc_start_o,
   output logic              hold_o,
   output logic              discharge_o,
   output logic              busy_o,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o
);
   localparam int MAX_CYC = max3(SETTLE_CYC, CLEAR_CYC, CONV_TIMEOUT);
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (SETTLE_CYC < 1 || CLEAR_CYC < 1 || CONV_TIMEOUT < 1) begin : g_bad_cyc
      $error("peak_conv_seq: phase lengths must be at least one cycle");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("peak_conv_seq: DATA_W must be positive");
   end

   phase_t           phase;
   logic             phase_chg;
   logic             tmr_exp;
   logic [CNT_W-1:0] limit;

   pkseq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .gate_i     (gate_i),
      .peak_i     (peak_i),
      .adc_done_i (adc_done_i),
      .tmr_exp    (tmr_exp),
      .phase_q    (phase),
      .phase_chg  (phase_chg)
   );

   always_comb begin
      unique case (phase)
         PH_SETTLE: limit = CNT_W'(SETTLE_CYC);
         PH_CONV:   limit = CNT_W'(CONV_TIMEOUT);
         PH_CLEAR:  limit = CNT_W'(CLEAR_CYC);
         default:   limit = CNT_W'(1);
      endcase
   end

   pkseq_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (phase_chg),
      .limit   (limit),
      .expired (tmr_exp)
   );

   pkseq_capture #(.DATA_W(DATA_W)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .take  ((phase == PH_CONV) && adc_done_i),
      .din   (adc_data_i),
      .valid (valid_o),
      .dout  (data_o)
   );

   assign hold_o      = (phase == PH_SETTLE) || (phase == PH_START) || (phase == PH_CONV);
   assign adc_start_o = (phase == PH_START);
   assign discharge_o = (phase == PH_CLEAR);
   assign busy_o      = (phase != PH_IDLE);
endmodule

// File: rtl/pkseq_chk.sv
module pkseq_chk #(
   parameter int CLEAR_CYC = 8
) (
   input logic clk,
   input logic rst_n,
   input logic gate_i,
   input logic busy_o,
   input logic hold_o,
   input logic discharge_o,
   input logic adc_start_o,
   input logic valid_o
);
   localparam int DW = $clog2(CLEAR_CYC + 2);
   logic [DW-1:0] dis_run;
   logic          gate_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_run   <= '0;
         gate_prev <= 1'b0;
      end else begin
         gate_prev <= gate_i;
         if (!discharge_o)                   dis_run <= '0;
         else if (dis_run != {DW{1'b1}})     dis_run <= dis_run + 1'b1;
      end
   end

   assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && gate_i && !gate_prev) |=> busy_o);
   assert_hold_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(hold_o && discharge_o));
   assert_hold_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_o) |-> discharge_o);
   assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start_o |=> !adc_start_o);
   assert_valid_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> discharge_o);
   assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   assert_clear_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dis_run <= DW'(CLEAR_CYC));
   assert_busy_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_o || discharge_o || adc_start_o) |-> busy_o);
endmodule

bind peak_conv_seq pkseq_chk #(.CLEAR_CYC(CLEAR_CYC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .gate_i      (gate_i),
   .busy_o      (busy_o),
   .hold_o      (hold_o),
   .discharge_o (discharge_o),
   .adc_start_o (adc_start_o),
   .valid_o     (valid_o)
);

// File: tb/tb_peak_conv_seq.sv
module tb_peak_conv_seq;
   localparam int DW = 12, SET = 16, CLR = 8, TMO = 240;

   logic clk = 1'b0, rst_n = 1'b0;
   logic gate_i = 1'b0, peak_i = 1'b0, adc_done_i = 1'b0;
   logic [DW-1:0] adc_data_i = '0;
   logic adc_start_o, hold_o, discharge_o, busy_o, valid_o;
   logic [DW-1:0] data_o;

   int checks = 0, fails = 0, n_valid = 0;
   logic [DW-1:0] exp_q[$];
   logic [DW-1:0] adc_next = '0;
   int  adc_lat = 3;
   bit  adc_en = 1'b1;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   peak_conv_seq #(.DATA_W(DW), .SETTLE_CYC(SET), .CLEAR_CYC(CLR), .CONV_TIMEOUT(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .peak_i(peak_i),
      .adc_done_i(adc_done_i), .adc_data_i(adc_data_i), .adc_start_o(adc_start_o),
      .hold_o(hold_o), .discharge_o(discharge_o), .busy_o(busy_o),
      .valid_o(valid_o), .data_o(data_o));

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // ADC model
   initial forever begin
      @(negedge clk);
      if (adc_start_o && adc_en) begin
         repeat (adc_lat) @(negedge clk);
         adc_done_i = 1'b1; adc_data_i = adc_next;
         @(negedge clk);
         adc_done_i = 1'b0;
      end
   end

   // Monitor / scoreboard
   initial begin
      int run = 0;
      forever begin
         @(negedge clk);
         if (!rst_n) continue;
         if (valid_o) begin
            n_valid++;
            check(exp_q.size() > 0, "R5 unexpected valid", 1, 0);
            if (exp_q.size() > 0) begin
               logic [DW-1:0] e;
               e = exp_q.pop_front();
               check(data_o == e, "R5 data", int'(data_o), int'(e));
            end
            check(discharge_o, "R5 valid in first clear cycle", int'(discharge_o), 1);
         end
         if (hold_o && discharge_o) check(1'b0, "R3 hold with discharge", 1, 0);
         if ((hold_o || discharge_o || adc_start_o) && !busy_o)
            check(1'b0, "R10 busy low while active", 0, 1);
         if (discharge_o) run++;
         else if (run > 0) begin
            check(run == CLR, "R6 clear length", run, CLR);
            run = 0;
         end
      end
   end

   task automatic wait_idle();
      while (busy_o) @(negedge clk);
      check(!busy_o && !hold_o && !discharge_o, "R6 idle after clear", int'(busy_o), 0);
   endtask

   // Full conversion; inj_gate pulses the gate during settling; keep_gate holds it high
   task automatic run_conv(input logic [DW-1:0] val, input int lat, input bit inj_gate, input bit keep_gate);
      int n;
      int nv0;
      nv0 = n_valid;
      exp_q.push_back(val);
      adc_next = val; adc_lat = lat; adc_en = 1'b1;
      @(negedge clk); gate_i = 1'b1;
      @(negedge clk);
      check(busy_o, "R2 busy after gate edge", int'(busy_o), 1);
      check(!hold_o, "R2 hold low while acquiring", int'(hold_o), 0);
      @(negedge clk);
      peak_i = 1'b1;
      n = 0;
      @(negedge clk);
      peak_i = 1'b0;
      if (!keep_gate) gate_i = 1'b0;
      check(hold_o, "R3 hold after peak", int'(hold_o), 1);
      while (!adc_start_o) begin
         n++;
         if (inj_gate && n == 4) gate_i = 1'b1;
         if (inj_gate && n == 6) gate_i = 1'b0;
         @(negedge clk);
      end
      check(n == SET, "R4 settle length", n, SET);
      @(negedge clk);
      check(!adc_start_o, "R4 single start pulse", int'(adc_start_o), 0);
      check(hold_o, "R3 hold kept while converting", int'(hold_o), 1);
      wait_idle();
      check(n_valid == nv0 + 1, "R5 one result", n_valid - nv0, 1);
   endtask

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int nv0;
      int m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !hold_o && !discharge_o && !adc_start_o && !valid_o,
            "R1 reset outputs", int'({busy_o, hold_o, discharge_o, adc_start_o, valid_o}), 0);

      run_conv(12'hA5C, 3, 1'b0, 1'b0);
      run_conv(12'h000, 1, 1'b0, 1'b0);
      run_conv(12'hFFF, 7, 1'b1, 1'b0);   // R8 gate pulse during settle ignored

      // R8: gate still high at return to idle must not restart
      run_conv(12'h3C1, 2, 1'b0, 1'b1);
      repeat (10) @(negedge clk);
      check(!busy_o, "R8 held gate no restart", int'(busy_o), 0);
      gate_i = 1'b0;
      @(negedge clk);

      // R7: gate closes before any peak
      nv0 = n_valid;
      gate_i = 1'b1;
      repeat (4) @(negedge clk);
      gate_i = 1'b0;
      @(negedge clk);
      check(discharge_o, "R7 clear after gate drop", int'(discharge_o), 1);
      wait_idle();
      check(n_valid == nv0, "R7 no valid", n_valid - nv0, 0);

      // R9: ADC never answers
      nv0 = n_valid;
      adc_en = 1'b0;
      gate_i = 1'b1;
      @(negedge clk); @(negedge clk);
      peak_i = 1'b1;
      @(negedge clk);
      peak_i = 1'b0; gate_i = 1'b0;
      while (!adc_start_o) @(negedge clk);
      m = 0;
      @(negedge clk);
      while (!discharge_o) begin m++; @(negedge clk); end
      check(m == TMO, "R9 timeout length", m, TMO);
      wait_idle();
      check(n_valid == nv0, "R9 no valid", n_valid - nv0, 0);
      adc_en = 1'b1;

      run_conv(12'h7E1, 4, 1'b0, 1'b0);
      check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule